// File: doc/BRIEF.md
# Per-Channel Overload Fault Counter

This block sits beside each converter channel and decides when repeated current limiting has turned into a persistent overload. Once per switching cycle the channel raises a strobe, and with it a flag saying whether that cycle was cut short by the cycle-by-cycle current limit. Each limited cycle adds one to a fault count. An isolated limited cycle does not reset the count. Only a run of eight clean cycles in a row returns the count to zero, so limiting that comes and goes still builds up toward a fault.

When the count reaches 256, the block raises a fault level and a one-cycle fault pulse. The shared restart logic uses these to stop the channel. The fault stays latched and further strobes are ignored until the restart logic pulses the clear input, the channel is disabled, or the counting mode is turned off. Turning the counting mode off covers plain cycle-by-cycle limiting and boost channels; in that mode the block never declares a fault. Each channel has its own instance, so every channel counts on its own.

Top module: `ovld_fault_cnt`

## Requirements
- R1: A strobed cycle with `ilim_hit` high, while the block is armed (enabled, counting mode on, no fault, no clear), raises `count` by exactly one on the next clock.
- R2: When the count reaches 256, `fault` goes high and `fault_pulse` is high for exactly one cycle on that same clock.
- R3: After the eighth consecutive strobed clean cycle (`ilim_hit` low), `count` returns to zero. After only seven consecutive clean cycles, `count` is unchanged.
- R4: A strobed limited cycle restarts the consecutive-clean run, so seven clean cycles, then one limited cycle, then seven clean cycles leave the count nonzero.
- R5: `count` never exceeds 256. While `fault` is high, strobes change nothing, and `fault` holds until a clear, a disable or counting mode off.
- R6: `clr` high sets `count` to 0 and `fault` to 0 on the next clock, and it wins over a limited strobe in the same cycle.
- R7: `chan_en` low clears `count`, the clean run and `fault`. While it stays low, strobes are ignored and `count` stays 0.
- R8: `cnt_en` low (plain limiting or boost channel) keeps `count` at 0 and `fault` low whatever strobes arrive.
- R9: Cycles without `cyc_stb` leave `count` and `fault` unchanged.
- R10: While synchronous reset is held, and on the clock after it, `count`, `fault` and `fault_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | One-cycle strobe marking the end of a switching cycle |
| ilim_hit | input | 1 | Current limit was active in the strobed cycle |
| chan_en | input | 1 | Channel enable; low clears and stops counting |
| cnt_en | input | 1 | Counting mode on; low selects non-counting limiting |
| clr | input | 1 | Clear from the restart controller |
| fault | output | 1 | Latched overload fault level |
| fault_pulse | output | 1 | One-cycle pulse when the fault is declared |
| count | output | 9 | Present fault count, 0 to 256 |

## Verification
Two events can fall in the same cycle: a clear from the restart controller and a strobe that carries a limited cycle. The clear must win, and the limited cycle must not be counted. The bench places `clr` together with a limited strobe, both right after a fault has latched and in the random phase. It then expects a count of zero and no fault on the next clock. The 256th limited strobe is also checked against the one-cycle pulse, and against the strobes that follow it, which must not move the saturated count.

// File: rtl/ovld_pkg.sv
package ovld_pkg;
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_LIMIT = 2'd1,
    EV_CLEAN = 2'd2
  } cyc_ev_t;
endpackage

// File: rtl/cycle_classifier.sv
module cycle_classifier
  import ovld_pkg::*;
(
  input  logic    cyc_stb,
  input  logic    ilim_hit,
  input  logic    armed,
  output cyc_ev_t ev
);
  always_comb begin
    ev = EV_IDLE;
    if (armed && cyc_stb) begin
      ev = ilim_hit ? EV_LIMIT : EV_CLEAN;
    end
  end
endmodule

// File: rtl/clean_run_tracker.sv
module clean_run_tracker
  import ovld_pkg::*;
#(
  parameter int CLEAN_LEN = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    flush,
  input  cyc_ev_t ev,
  output logic    run_done
);
  localparam int RUN_W = (CLEAN_LEN > 1) ? $clog2(CLEAN_LEN) : 1;
  localparam logic [RUN_W-1:0] LAST = RUN_W'(CLEAN_LEN - 1);

  logic [RUN_W-1:0] run_q;

  assign run_done = (ev == EV_CLEAN) && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      run_q <= '0;
    end else begin
      case (ev)
        EV_LIMIT: run_q <= '0;
        EV_CLEAN: run_q <= run_done ? '0 : run_q + 1'b1;
        default:  run_q <= run_q;
      endcase
    end
  end
endmodule

// File: rtl/limit_accumulator.sv
module limit_accumulator
  import ovld_pkg::*;
#(
  parameter int FAULT_LIM = 256,
  localparam int CNT_W = $clog2(FAULT_LIM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  cyc_ev_t          ev,
  input  logic             run_done,
  output logic [CNT_W-1:0] cnt,
  output logic             fault,
  output logic             fault_rise
);
  localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(FAULT_LIM);
  localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(FAULT_LIM - 1);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt        <= '0;
      fault      <= 1'b0;
      fault_rise <= 1'b0;
    end else begin
      fault_rise <= 1'b0;
      case (ev)
        EV_LIMIT: begin
          if (cnt != LIM_V) begin
            cnt <= cnt + 1'b1;
          end
          if (cnt == LIM_M1) begin
            fault      <= 1'b1;
            fault_rise <= 1'b1;
          end
        end
        EV_CLEAN: begin
          if (run_done) begin
            cnt <= '0;
          end
        end
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ovld_fault_cnt.sv
module ovld_fault_cnt
  import ovld_pkg::*;
#(
  parameter int FAULT_LIM = 256,
  parameter int CLEAN_LEN = 8,
  localparam int CNT_W = $clog2(FAULT_LIM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_stb,
  input  logic             ilim_hit,
  input  logic             chan_en,
  input  logic             cnt_en,
  input  logic             clr,
  output logic             fault,
  output logic             fault_pulse,
  output logic [CNT_W-1:0] count
);
  cyc_ev_t ev;
  logic    armed;
  logic    flush;
  logic    run_done;

  assign flush = clr || !chan_en || !cnt_en;
  assign armed = !flush && !fault;

  cycle_classifier u_cls (
    .cyc_stb  (cyc_stb),
    .ilim_hit (ilim_hit),
    .armed    (armed),
    .ev       (ev)
  );

  clean_run_tracker #(.CLEAN_LEN(CLEAN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .ev       (ev),
    .run_done (run_done)
  );

  limit_accumulator #(.FAULT_LIM(FAULT_LIM)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .ev         (ev),
    .run_done   (run_done),
    .cnt        (count),
    .fault      (fault),
    .fault_rise (fault_pulse)
  );
endmodule

// File: rtl/ovld_fault_cnt_chk.sv
module ovld_fault_cnt_chk #(
  parameter int FAULT_LIM = 256,
  localparam int CNT_W = $clog2(FAULT_LIM + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_stb,
  input logic             ilim_hit,
  input logic             chan_en,
  input logic             cnt_en,
  input logic             clr,
  input logic             fault,
  input logic             fault_pulse,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(FAULT_LIM);

  // R1
  hit_increments_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && ilim_hit && chan_en && cnt_en && !clr && !fault)
      |=> (count == $past(count) + 1'b1));

  // R2
  pulse_with_fault_chk: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> (fault && count == LIM_V));

  // R5
  count_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    count <= LIM_V);

  // R5
  fault_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (fault && !clr && chan_en && cnt_en) |=> (fault && count == LIM_V && !fault_pulse));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0 && !fault));

  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (count == '0 && !fault));

  // R8
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> (count == '0 && !fault && !fault_pulse));

  // R9
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cyc_stb && chan_en && cnt_en && !clr) |=> $stable(count));
endmodule

bind ovld_fault_cnt ovld_fault_cnt_chk #(.FAULT_LIM(FAULT_LIM)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cyc_stb     (cyc_stb),
  .ilim_hit    (ilim_hit),
  .chan_en     (chan_en),
  .cnt_en      (cnt_en),
  .clr         (clr),
  .fault       (fault),
  .fault_pulse (fault_pulse),
  .count       (count)
);

// File: tb/ovld_fault_cnt_bench.sv
module ovld_fault_cnt_bench;
  localparam int LIM = 256;

  logic clk = 1'b0;
  logic rst, cyc_stb, ilim_hit, chan_en, cnt_en, clr;
  logic fault, fault_pulse;
  logic [8:0] count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int  m_cnt, m_run;
  bit  m_fault, m_pulse;

  always #4 clk = ~clk;

  ovld_fault_cnt u_ovld_fault_cnt (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .ilim_hit(ilim_hit),
    .chan_en(chan_en), .cnt_en(cnt_en), .clr(clr),
    .fault(fault), .fault_pulse(fault_pulse), .count(count)
  );

  task automatic model_reset();
    m_cnt = 0; m_run = 0; m_fault = 0; m_pulse = 0;
  endtask

  task automatic model_step(input bit s, input bit h, input bit e, input bit c, input bit cl);
    m_pulse = 0;
    if (!e || !c || cl) begin
      m_cnt = 0; m_run = 0; m_fault = 0;
    end else if (s && !m_fault) begin
      if (h) begin
        m_run = 0;
        if (m_cnt < LIM) m_cnt++;
        if (m_cnt == LIM) begin m_fault = 1; m_pulse = 1; end
      end else if (m_run == 7) begin
        m_run = 0; m_cnt = 0;
      end else begin
        m_run++;
      end
    end
  endtask

  task automatic check(input string req);
    total++;
    if (count !== 9'(m_cnt) || fault !== m_fault || fault_pulse !== m_pulse) begin
      bad++;
      $display("FAIL %s: count=%0d fault=%0b pulse=%0b expected count=%0d fault=%0b pulse=%0b",
               req, count, fault, fault_pulse, m_cnt, m_fault, m_pulse);
    end
  endtask

  // called at a falling edge; ends at the next falling edge
  task automatic step(input bit s, input bit h, input bit e, input bit c, input bit cl,
                      input string req);
    cyc_stb = s; ilim_hit = h; chan_en = e; cnt_en = c; clr = cl;
    model_step(s, h, e, c, cl);
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0051_7eed));
    rst = 1; cyc_stb = 0; ilim_hit = 0; chan_en = 1; cnt_en = 1; clr = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10");
    rst = 0;
    step(0, 0, 1, 1, 0, "R10");

    // R1: plain accumulation
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, "R1");
    // R4: seven clean, one limited, seven clean keeps count
    for (int i = 0; i < 7; i++) step(1, 0, 1, 1, 0, "R4");
    step(1, 1, 1, 1, 0, "R4");
    for (int i = 0; i < 7; i++) step(1, 0, 1, 1, 0, "R4");
    // R3: the eighth clean cycle clears
    step(1, 0, 1, 1, 0, "R3");
    // R9: idle cycles between strobes
    step(1, 1, 1, 1, 0, "R1");
    for (int i = 0; i < 10; i++) step(0, 1, 1, 1, 0, "R9");

    // R2: reach the limit
    for (int i = 0; i < LIM - 1; i++) step(1, 1, 1, 1, 0, "R2");
    // R5: saturated and held, clean cycles ignored
    for (int i = 0; i < 12; i++) step(1, i[0], 1, 1, 0, "R5");
    // R6: clear together with a limited strobe
    step(1, 1, 1, 1, 1, "R6");
    step(1, 1, 1, 1, 0, "R6");

    // R7: fault then channel disable
    for (int i = 0; i < LIM; i++) step(1, 1, 1, 1, 0, "R2");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 0, "R7");
    // R8: counting mode off
    for (int i = 0; i < LIM + 20; i++) step(1, 1, 1, 0, 0, "R8");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit s, h, e, cl;
      s  = ($urandom % 4) != 0;
      h  = ($urandom % 16) < 13;
      e  = ($urandom % 700) != 0;
      cl = ($urandom % 400) == 0;
      step(s, h, e, 1, cl, "R1");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule